// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break

This block is the transmit half of an asynchronous serial port. A character of 8 or 9 bits is written through a single-cycle strobe into a one-entry holding register. When the shift engine is free, the character moves into it. The engine then puts out a frame on a single line that idles high. Bit timing comes from an integer divider: the system clock is divided by the divisor value to give an oversampling tick, and every bit is held for 16 of those ticks. A frame can carry an optional parity bit, even or odd.

On request, the engine sends break characters in place of data. A break character is a run of zero bits whose length depends on the character width and on a long-break option. The block reports three things: whether the holding register can take a new character, whether all transmission has finished, and whether a write was lost because the register was still occupied.

Top module: `sertx_core`

## Requirements
- R1: After reset, `txd` is 1, `hold_empty` is 1, `tx_done` is 1 and `wr_collide` is 0.
- R2: Every bit of a frame, and every zero of a break, is held on `txd` for exactly 16 × `divisor` clock cycles.
- R3: A data frame is sent in this order: a 0 start bit, then `wr_data[7:0]` least significant bit first, then `wr_data[8]` only when `nine_bit`=1, then a parity bit only when `par_en`=1, then a 1 stop bit. The format inputs are taken when the frame is loaded into the shifter.
- R4: The parity bit is chosen from the ones in the data bits it covers (8 bits, or 9 bits when `nine_bit`=1). With `par_odd`=0 the total number of ones in the data bits plus the parity bit is even. With `par_odd`=1 that total is odd.
- R5: While `brk_req`=1 at a frame boundary, or while the line is idle, the engine sends a block of zero bits. The block is 10 bits long, or 11 bits when `nine_bit`=1. With `brk_long`=1 it is 13 bits, or 14 bits when `nine_bit`=1. Blocks follow each other back to back while `brk_req` stays high. A break takes priority over a waiting character, which is sent once the break ends.
- R6: An accepted write clears `hold_empty` at the next clock edge. `hold_empty` sets again in the cycle after the character moves into the shifter. When the engine is idle, this happens one clock after the write, and the start bit appears in that same cycle.
- R7: `tx_done` is 1 exactly when the shifter is idle and the holding register is empty. It is 0 while a frame or a break is on the line.
- R8: A write made while the holding register is full is ignored, unless the held character moves into the shifter in that same cycle. An ignored write sets `wr_collide`. The next accepted write clears `wr_collide`. An ignored character is never transmitted.
- R9: While `en`=0, `txd` is 1 from the next clock onward and any frame in progress is abandoned. A character in the holding register stays there and is sent after `en` returns to 1.
- R10: While `divisor` is 0, no frame or break is started, so the line stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Transmitter enable |
| divisor | input | DIV_W (13) | System clocks per oversampling tick; 0 halts the tick |
| nine_bit | input | 1 | 1 selects 9-bit characters |
| par_en | input | 1 | 1 appends a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| brk_req | input | 1 | Request to send break blocks |
| brk_long | input | 1 | 1 selects the long break lengths |
| wr_stb | input | 1 | Single-cycle write strobe |
| wr_data | input | 9 | Character to send; bit 8 is used only in 9-bit mode |
| txd | output | 1 | Serial output line, idle high |
| hold_empty | output | 1 | Holding register can take a character |
| tx_done | output | 1 | Nothing in flight and nothing waiting |
| wr_collide | output | 1 | A write was dropped because the register was full |

## Verification
A write strobe can arrive in the same clock cycle that the held character is handed to the shifter. The design must then accept the new character rather than flag a collision. The bench provokes this by pulsing the strobe on three consecutive cycles while the engine is idle. The first write fills the register. The second lands exactly on the hand-over cycle and must be accepted. The third must set `wr_collide`. The result is judged at the line: the first two characters must come out in order, and nothing must follow them.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int FRM_W = 14;
    localparam int LEN_W = 4;
    localparam int CHR_W = 9;

    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_DATA  = 2'd1,
        SH_BREAK = 2'd2
    } sh_mode_e;

    typedef struct packed {
        logic nine;
        logic par_en;
        logic par_odd;
    } fmt_t;

    typedef struct packed {
        logic [FRM_W-1:0] bits;
        logic [LEN_W-1:0] len;
    } frame_t;

    function automatic frame_t make_data_frame(input logic [CHR_W-1:0] d, input fmt_t f);
        frame_t fr;
        logic   p;
        int     pos;
        fr.bits      = '1;
        fr.bits[0]   = 1'b0;
        fr.bits[8:1] = d[7:0];
        p            = ^d[7:0];
        pos          = 9;
        if (f.nine) begin
            fr.bits[pos] = d[8];
            p            = p ^ d[8];
            pos++;
        end
        if (f.par_en) begin
            fr.bits[pos] = p ^ f.par_odd;
            pos++;
        end
        fr.bits[pos] = 1'b1;
        pos++;
        fr.len = LEN_W'(pos);
        return fr;
    endfunction

    function automatic frame_t make_break_frame(input fmt_t f, input logic lng);
        frame_t fr;
        fr.bits = '0;
        fr.len  = LEN_W'(10 + (f.nine ? 1 : 0) + (lng ? 3 : 0));
        return fr;
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] divisor,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic             div_ok;

    assign div_ok = (divisor != '0);
    assign tick   = run && div_ok && (cnt >= divisor - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else if (div_ok) begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_stb,
    input  logic [CHR_W-1:0] wr_data,
    input  logic             take,
    output logic             full,
    output logic [CHR_W-1:0] data,
    output logic             collide
);
    logic accept;

    assign accept = wr_stb && (!full || take);

    always_ff @(posedge clk) begin
        if (rst) begin
            full    <= 1'b0;
            data    <= '0;
            collide <= 1'b0;
        end else if (accept) begin
            data    <= wr_data;
            full    <= 1'b1;
            collide <= 1'b0;
        end else begin
            if (take)   full    <= 1'b0;
            if (wr_stb) collide <= 1'b1;
        end
    end
endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             div_ok,
    input  logic             tick,
    input  logic             brk_req,
    input  logic             brk_long,
    input  fmt_t             fmt,
    input  logic             hold_full,
    input  logic [CHR_W-1:0] hold_data,
    output logic             take,
    output logic             busy,
    output logic             txd
);
    localparam int OVS_W = (OVS > 1) ? $clog2(OVS) : 1;

    sh_mode_e         mode;
    logic [FRM_W-1:0] bits;
    logic [LEN_W-1:0] rem;
    logic [OVS_W-1:0] ovs;
    logic             bit_end;
    logic             last_end;
    logic             slot;
    logic             start_brk;
    logic             start_data;
    frame_t           nxt;

    assign busy       = (mode != SH_IDLE);
    assign bit_end    = busy && tick && (ovs == OVS_W'(OVS - 1));
    assign last_end   = bit_end && (rem == LEN_W'(1));
    assign slot       = (!busy || last_end) && en && div_ok;
    assign start_brk  = slot && brk_req;
    assign start_data = slot && !brk_req && hold_full;
    assign take       = start_data;
    assign txd        = !busy || bits[0];

    always_comb begin
        if (brk_req) nxt = make_break_frame(fmt, brk_long);
        else         nxt = make_data_frame(hold_data, fmt);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            mode <= SH_IDLE;
            bits <= '1;
            rem  <= '0;
            ovs  <= '0;
        end else if (start_brk || start_data) begin
            mode <= start_brk ? SH_BREAK : SH_DATA;
            bits <= nxt.bits;
            rem  <= nxt.len;
            ovs  <= '0;
        end else if (last_end) begin
            mode <= SH_IDLE;
            bits <= '1;
            rem  <= '0;
            ovs  <= '0;
        end else if (bit_end) begin
            bits <= {1'b1, bits[FRM_W-1:1]};
            rem  <= rem - LEN_W'(1);
            ovs  <= '0;
        end else if (busy && tick) begin
            ovs <= ovs + OVS_W'(1);
        end
    end
endmodule

// File: rtl/sertx_core.sv
module sertx_core
    import sertx_pkg::*;
#(
    parameter int DIV_W = 13,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] divisor,
    input  logic             nine_bit,
    input  logic             par_en,
    input  logic             par_odd,
    input  logic             brk_req,
    input  logic             brk_long,
    input  logic             wr_stb,
    input  logic [8:0]       wr_data,
    output logic             txd,
    output logic             hold_empty,
    output logic             tx_done,
    output logic             wr_collide
);
    logic             tick;
    logic             sh_busy;
    logic             take;
    logic             h_full;
    logic [CHR_W-1:0] h_data;
    fmt_t             fmt;

    assign fmt = '{nine: nine_bit, par_en: par_en, par_odd: par_odd};

    sertx_baud #(.DIV_W(DIV_W)) baud_i (
        .clk     (clk),
        .rst     (rst),
        .run     (sh_busy),
        .divisor (divisor),
        .tick    (tick)
    );

    sertx_hold hold_i (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_data (wr_data),
        .take    (take),
        .full    (h_full),
        .data    (h_data),
        .collide (wr_collide)
    );

    sertx_shift #(.OVS(OVS)) shift_i (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .div_ok    (divisor != '0),
        .tick      (tick),
        .brk_req   (brk_req),
        .brk_long  (brk_long),
        .fmt       (fmt),
        .hold_full (h_full),
        .hold_data (h_data),
        .take      (take),
        .busy      (sh_busy),
        .txd       (txd)
    );

    assign hold_empty = !h_full;
    assign tx_done    = !sh_busy && !h_full;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
    parameter int DIV_W = 13
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic [DIV_W-1:0] divisor,
    input logic             wr_stb,
    input logic             txd,
    input logic             hold_empty,
    input logic             tx_done,
    input logic             wr_collide,
    input logic             busy
);
    AST_OFF_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
        !en |=> txd); // R9

    AST_ZERO_DIV_STILL: assert property (@(posedge clk) disable iff (rst)
        (!busy && divisor == '0) |=> !busy); // R10

    AST_WR_FILLS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && hold_empty) |=> !hold_empty); // R6

    AST_COLLIDE_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(wr_collide) |-> ($past(wr_stb) && !$past(hold_empty))); // R8

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (rst)
        tx_done |-> (hold_empty && txd)); // R7
endmodule

bind sertx_core sertx_chk #(.DIV_W(DIV_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .divisor    (divisor),
    .wr_stb     (wr_stb),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .wr_collide (wr_collide),
    .busy       (sh_busy)
);

// File: tb/sertx_core_tb_top.sv
module sertx_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b1;
    logic [12:0] divisor = 13'd2;
    logic        nine_bit = 1'b0, par_en = 1'b0, par_odd = 1'b0;
    logic        brk_req = 1'b0, brk_long = 1'b0;
    logic        wr_stb = 1'b0;
    logic [8:0]  wr_data = '0;
    logic        txd, hold_empty, tx_done, wr_collide;

    int n_run = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sertx_core dut_i (
        .clk(clk), .rst(rst), .en(en), .divisor(divisor),
        .nine_bit(nine_bit), .par_en(par_en), .par_odd(par_odd),
        .brk_req(brk_req), .brk_long(brk_long),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done), .wr_collide(wr_collide)
    );

    // {nine_bit, par_en, par_odd, data[8:0]}
    localparam logic [11:0] VEC [6] = '{
        {3'b000, 9'h055}, {3'b010, 9'h0F0}, {3'b011, 9'h0F1},
        {3'b100, 9'h1C3}, {3'b110, 9'h100}, {3'b101, 9'h0FF}
    };

    task automatic check(input string tag, input longint act, input longint exp);
        n_run++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic void expect_frame(input logic [8:0] d, input logic nb, input logic pe,
                                         input logic po, output logic [13:0] b, output int n);
        int ones = 0;
        b = '1;
        b[0] = 1'b0;
        for (int i = 0; i < 8; i++) begin
            b[i+1] = d[i];
            ones += int'(d[i]);
        end
        n = 9;
        if (nb) begin b[n] = d[8]; ones += int'(d[8]); n++; end
        if (pe) begin b[n] = ((ones % 2) == 1) ^ po; n++; end
        b[n] = 1'b1;
        n++;
    endfunction

    task automatic wr(input logic [8:0] d);
        wr_data = d; wr_stb = 1'b1;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic wait_start(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            if (txd == 1'b0) begin ok = 1'b1; return; end
            @(negedge clk);
        end
    endtask

    task automatic grab(input int n, output logic [13:0] b);
        int d = int'(divisor);
        b = '1;
        repeat (8 * d) @(negedge clk);
        b[0] = txd;
        for (int k = 1; k < n; k++) begin
            repeat (16 * d) @(negedge clk);
            b[k] = txd;
        end
    endtask

    task automatic low_run(input int drop_at, output int c);
        c = 0;
        while (txd == 1'b0 && c < 20000) begin
            c++;
            if (c == drop_at) brk_req = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++; n_bad++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        logic [13:0] got, exp_b;
        int n, c;
        bit ok;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 txd", txd, 1);
        check("R1 hold_empty", hold_empty, 1);
        check("R1 tx_done", tx_done, 1);
        check("R1 wr_collide", wr_collide, 0);

        // R3/R4 table walk
        foreach (VEC[i]) begin
            {nine_bit, par_en, par_odd} = VEC[i][11:9];
            divisor = 13'd2;
            @(negedge clk);
            wr(VEC[i][8:0]);
            wait_start(ok);
            check("R6 start", ok, 1);
            check("R7 busy", tx_done, 0);
            expect_frame(VEC[i][8:0], VEC[i][11], VEC[i][10], VEC[i][9], exp_b, n);
            grab(n, got);
            check(VEC[i][10] ? "R4 parity frame" : "R3 frame", got, exp_b);
            repeat (8 * 2 + 2) @(negedge clk);
            check("R7 done", tx_done, 1);
        end

        // R2 bit length, divisor 3
        {nine_bit, par_en, par_odd} = 3'b000;
        divisor = 13'd3;
        wr(9'h001);
        wait_start(ok);
        low_run(0, c);
        check("R2 start bit cycles", c, 48);
        repeat (16 * 3 * 10) @(negedge clk);

        // R6 hold_empty timing
        divisor = 13'd2;
        wr(9'h0AA);
        check("R6 full after write", hold_empty, 0);
        @(negedge clk);
        check("R6 empty after move", hold_empty, 1);
        check("R6 start same cycle", txd, 0);
        repeat (16 * 2 * 11) @(negedge clk);

        // R8 strobes on consecutive cycles: second lands on the hand-over
        wr_data = 9'h031; wr_stb = 1'b1;
        @(negedge clk);
        wr_data = 9'h0C4;
        @(negedge clk);
        wr_data = 9'h07E;
        @(negedge clk);
        wr_stb = 1'b0;
        check("R8 collide set", wr_collide, 1);
        check("R8 second held", hold_empty, 0);
        wait_start(ok);
        expect_frame(9'h031, 0, 0, 0, exp_b, n);
        grab(n, got);
        check("R8 first frame", got, exp_b);
        wait_start(ok);
        expect_frame(9'h0C4, 0, 0, 0, exp_b, n);
        grab(n, got);
        check("R8 second frame", got, exp_b);
        c = 0;
        for (int i = 0; i < 16 * 2 * 12; i++) begin
            if (txd == 1'b0) c++;
            @(negedge clk);
        end
        check("R8 dropped char not sent", c, 0);
        wr(9'h012);
        check("R8 collide cleared", wr_collide, 0);
        repeat (16 * 2 * 11) @(negedge clk);

        // R5 break lengths, divisor 1
        divisor = 13'd1;
        for (int m = 0; m < 4; m++) begin
            nine_bit = m[0]; brk_long = m[1];
            brk_req = 1'b1;
            @(negedge clk);
            low_run(20, c);
            check("R5 break length", c, (10 + m[0] + (m[1] ? 3 : 0)) * 16);
            check("R5 line high after", txd, 1);
            repeat (4) @(negedge clk);
        end
        nine_bit = 1'b0; brk_long = 1'b0;
        brk_req = 1'b1;
        @(negedge clk);
        low_run(160 + 20, c);
        check("R5 repeated blocks", c, 320);

        // R5 break ahead of waiting data (held while disabled)
        en = 1'b0;
        @(negedge clk);
        wr(9'h0FF);
        brk_req = 1'b1;
        en = 1'b1;
        @(negedge clk);
        low_run(20, c);
        check("R5 break then start bit", c, 160 + 16);
        check("R5 data taken after break", hold_empty, 1);
        repeat (16 * 10) @(negedge clk);

        // R9 enable low holds data, then abort mid-frame
        divisor = 13'd2;
        en = 1'b0;
        @(negedge clk);
        wr(9'h05A);
        c = 0;
        for (int i = 0; i < 200; i++) begin
            if (txd == 1'b0) c++;
            @(negedge clk);
        end
        check("R9 line idle while off", c, 0);
        check("R9 data waits", hold_empty, 0);
        check("R7 not done with data waiting", tx_done, 0);
        en = 1'b1;
        @(negedge clk);
        wait_start(ok);
        expect_frame(9'h05A, 0, 0, 0, exp_b, n);
        grab(n, got);
        check("R9 held data sent", got, exp_b);
        repeat (40) @(negedge clk);
        wr(9'h000);
        wait_start(ok);
        repeat (40) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check("R9 abort line high", txd, 1);
        en = 1'b1;
        c = 0;
        for (int i = 0; i < 100; i++) begin
            if (txd == 1'b0) c++;
            @(negedge clk);
        end
        check("R9 no restart", c, 0);

        // R10 zero divisor
        divisor = 13'd0;
        wr(9'h033);
        c = 0;
        for (int i = 0; i < 300; i++) begin
            if (txd == 1'b0) c++;
            @(negedge clk);
        end
        check("R10 no start", c, 0);
        check("R10 data waits", hold_empty, 0);
        divisor = 13'd2;
        wait_start(ok);
        check("R10 starts after divisor set", ok, 1);
        expect_frame(9'h033, 0, 0, 0, exp_b, n);
        grab(n, got);
        check("R10 frame", got, exp_b);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
        $finish;
    end
endmodule